// File: doc/BRIEF.md
# DMA Control and Status Register Bank

This block is the software-facing register bank of a DMA engine. A processor reaches it through an AXI4-Lite slave port with 32-bit data and an 11-bit byte address. Through that port software reads fixed identification words and uses a scratch word. It also programs a transfer descriptor: the two base addresses, the two strides, two lengths and a set of flags. It then controls the interrupt mask and pending state and reads a few debug words that come straight from input pins.

Software launches a transfer by writing 1 to the submit word. The bank then offers the stored descriptor to the DMA core with a valid/ready handshake. When the core accepts it, the bank advances a transfer counter and posts a "queued" interrupt. Completion responses from the core that carry an end-of-transfer mark post a "done" interrupt. The interrupt line is high while any enabled pending bit is set. Software clears a pending bit by writing 1 to it.

Top module: `dmac_csr_bank`

## Requirements
- R1: Byte address bits [10:2] select one of 512 words; a read of any word not listed here (for example 0x014 or 0x7FC) returns 0.
- R2: After reset, 0x000 reads 0x00040361, 0x00C reads 0x444D4143, 0x010 reads 0x00002101, 0x080 reads 0x3 and 0x40C reads 0x3. Every other word reads 0, except 0x418 (see R5). Writes to 0x000, 0x00C and 0x010 do not change them.
- R3: Word 0x008 reads back the last value written to it.
- R4: The destination address (0x410) and source address (0x414) words store 32 bits. The destination stride (0x420) and source stride (0x424) words store 24 bits. In all four, bit 0 always reads 0 and drives 0 on the matching descriptor output.
- R5: The X length (0x418) stores 24 bits with bits [1:0] forced to 1, so it reads 0x3 after reset. The Y length (0x41C) stores all 24 bits.
- R6: Bit 0 of 0x400 drives `enable_o`. Bits [2:0] of 0x40C drive `flags_o`, and unused bits of both words read 0.
- R7: Writing a word with bit 0 set to 0x408 raises `req_valid`. Bit 0 of 0x408 reads 1 and `req_valid` stays high until a cycle with `req_ready` high, after which both read 0.
- R8: Each accepted descriptor adds 1 to the transfer counter at 0x404 and sets pending bit 0.
- R9: A handshake on the response input with `resp_eot` high sets pending bit 1. A handshake without it changes nothing. `resp_ready` is always high.
- R10: 0x088 reads the raw pending bits, 0x084 reads the pending bits ANDed with the mask at 0x080, and `irq` is high when any masked pending bit is set. Writing 1 to a bit of 0x084 clears it, and writing 0 leaves it set.
- R11: Words 0x434, 0x438, 0x43C, 0x440 and 0x444 read the debug inputs `dbg_dst_addr`, `dbg_src_addr`, `dbg_status`, `dbg_id0` and `dbg_id1`.
- R12: The write address and write data channels are accepted independently and in either order. The write happens only once both have arrived. BRESP and RRESP are always OKAY (0), and a response stays valid until taken.
- R13: Reset returns every writable word to its R2/R5 value, even after all of them were loaded with all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | 11 | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 32 | Write data |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | 11 | Read byte address |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| enable_o | output | 1 | Engine enable |
| flags_o | output | 3 | Transfer flags |
| req_valid | output | 1 | Descriptor offered to the core |
| req_ready | input | 1 | Core accepts descriptor |
| req_dst_addr | output | 32 | Destination base address |
| req_src_addr | output | 32 | Source base address |
| req_xlen | output | 24 | X length |
| req_ylen | output | 24 | Y length |
| req_dst_stride | output | 24 | Destination stride |
| req_src_stride | output | 24 | Source stride |
| resp_valid | input | 1 | Completion response valid |
| resp_ready | output | 1 | Completion response ready |
| resp_eot | input | 1 | Response marks end of transfer |
| irq | output | 1 | Level interrupt |
| dbg_dst_addr | input | 32 | Debug destination address |
| dbg_src_addr | input | 32 | Debug source address |
| dbg_status | input | 32 | Debug status |
| dbg_id0 | input | 32 | Debug ID word 0 |
| dbg_id1 | input | 32 | Debug ID word 1 |

## Verification
The assertions rely on a few things about the environment. Reset is low from time zero. The core changes pending state only through the request and response handshakes. The only other path is a register write, which the assertions see as the write response rising. The stimulus drives every input half a cycle away from the clock edge, and it keeps each AXI valid high until its ready has been seen. It never writes the submit word in the cycle the core accepts a descriptor, so acceptance always ends the offer.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;

    localparam int CSR_ADDR_W = 11;
    localparam int WORD_W     = CSR_ADDR_W - 2;

    localparam logic [31:0] VERSION_WORD = 32'h0004_0361;
    localparam logic [31:0] IDENT_WORD   = 32'h444D_4143;
    localparam logic [31:0] IFACE_WORD   = 32'h0000_2101;

    localparam logic [WORD_W-1:0] W_VERSION  = 9'h000;
    localparam logic [WORD_W-1:0] W_SCRATCH  = 9'h002;
    localparam logic [WORD_W-1:0] W_IDENT    = 9'h003;
    localparam logic [WORD_W-1:0] W_IFACE    = 9'h004;
    localparam logic [WORD_W-1:0] W_IRQ_MASK = 9'h020;
    localparam logic [WORD_W-1:0] W_IRQ_PEND = 9'h021;
    localparam logic [WORD_W-1:0] W_IRQ_RAW  = 9'h022;
    localparam logic [WORD_W-1:0] W_CTRL     = 9'h100;
    localparam logic [WORD_W-1:0] W_XFER_ID  = 9'h101;
    localparam logic [WORD_W-1:0] W_SUBMIT   = 9'h102;
    localparam logic [WORD_W-1:0] W_FLAGS    = 9'h103;
    localparam logic [WORD_W-1:0] W_DST      = 9'h104;
    localparam logic [WORD_W-1:0] W_SRC      = 9'h105;
    localparam logic [WORD_W-1:0] W_XLEN     = 9'h106;
    localparam logic [WORD_W-1:0] W_YLEN     = 9'h107;
    localparam logic [WORD_W-1:0] W_DSTRIDE  = 9'h108;
    localparam logic [WORD_W-1:0] W_SSTRIDE  = 9'h109;
    localparam logic [WORD_W-1:0] W_DBG_DST  = 9'h10D;
    localparam logic [WORD_W-1:0] W_DBG_SRC  = 9'h10E;
    localparam logic [WORD_W-1:0] W_DBG_STAT = 9'h10F;
    localparam logic [WORD_W-1:0] W_DBG_ID0  = 9'h110;
    localparam logic [WORD_W-1:0] W_DBG_ID1  = 9'h111;

    localparam int IRQ_N = 2;

    typedef struct packed {
        logic              wen;
        logic [WORD_W-1:0] widx;
        logic [31:0]       wdata;
    } csr_wr_t;

endpackage

// File: rtl/dmac_csr_axil.sv
module dmac_csr_axil
    import dmac_csr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  awvalid,
    output logic                  awready,
    input  logic [CSR_ADDR_W-1:0] awaddr,
    input  logic                  wvalid,
    output logic                  wready,
    input  logic [31:0]           wdata,
    output logic                  bvalid,
    input  logic                  bready,
    output logic [1:0]            bresp,
    input  logic                  arvalid,
    output logic                  arready,
    input  logic [CSR_ADDR_W-1:0] araddr,
    output logic                  rvalid,
    input  logic                  rready,
    output logic [31:0]           rdata,
    output logic [1:0]            rresp,
    output csr_wr_t               wr_o,
    output logic [WORD_W-1:0]     rd_idx_o,
    input  logic [31:0]           rd_data_i
);

    typedef struct packed {
        logic              aw_held;
        logic [WORD_W-1:0] aw_idx;
        logic              w_held;
        logic [31:0]       w_data;
        logic              bvalid;
        logic              rvalid;
        logic [31:0]       rdata;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     fire;
    logic     unused_lsbs;

    assign unused_lsbs = ^{awaddr[1:0], araddr[1:0]};

    always_comb begin
        st_d    = st_q;
        awready = !st_q.aw_held;
        wready  = !st_q.w_held;
        arready = !st_q.rvalid;
        fire    = st_q.aw_held && st_q.w_held && !st_q.bvalid;

        if (awvalid && awready) begin
            st_d.aw_held = 1'b1;
            st_d.aw_idx  = awaddr[CSR_ADDR_W-1:2];
        end
        if (wvalid && wready) begin
            st_d.w_held = 1'b1;
            st_d.w_data = wdata;
        end
        if (fire) begin
            st_d.aw_held = 1'b0;
            st_d.w_held  = 1'b0;
            st_d.bvalid  = 1'b1;
        end else if (st_q.bvalid && bready) begin
            st_d.bvalid = 1'b0;
        end

        if (arvalid && arready) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_data_i;
        end else if (st_q.rvalid && rready) begin
            st_d.rvalid = 1'b0;
        end

        wr_o.wen  = fire;
        wr_o.widx = st_q.aw_idx;
        wr_o.wdata = st_q.w_data;
        rd_idx_o  = araddr[CSR_ADDR_W-1:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bvalid = st_q.bvalid;
    assign bresp  = 2'b00;
    assign rvalid = st_q.rvalid;
    assign rdata  = st_q.rdata;
    assign rresp  = 2'b00;

endmodule

// File: rtl/dmac_csr_irq.sv
module dmac_csr_irq
    import dmac_csr_pkg::*;
#(
    parameter int N = IRQ_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  csr_wr_t      wr_i,
    input  logic [N-1:0] set_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] pend;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i.wen && wr_i.widx == W_IRQ_MASK)
            st_d.mask = wr_i.wdata[N-1:0];
        if (wr_i.wen && wr_i.widx == W_IRQ_PEND)
            st_d.pend = st_q.pend & ~wr_i.wdata[N-1:0];
        // a new event in the same cycle as a clear must not be lost
        st_d.pend = st_d.pend | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= {N{1'b1}};
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.pend & st_q.mask);

endmodule

// File: rtl/dmac_csr_regs.sv
module dmac_csr_regs
    import dmac_csr_pkg::*;
#(
    parameter int DADDR_W = 32,
    parameter int LEN_W   = 24,
    parameter int BEAT_W  = 1,
    parameter int ALIGN_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  csr_wr_t            wr_i,
    input  logic [WORD_W-1:0]  rd_idx_i,
    output logic [31:0]        rd_data_o,
    input  logic [IRQ_N-1:0]   pend_i,
    input  logic [IRQ_N-1:0]   mask_i,
    output logic [IRQ_N-1:0]   set_o,
    output logic               enable_o,
    output logic [2:0]         flags_o,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [DADDR_W-1:0] req_dst_addr,
    output logic [DADDR_W-1:0] req_src_addr,
    output logic [LEN_W-1:0]   req_xlen,
    output logic [LEN_W-1:0]   req_ylen,
    output logic [LEN_W-1:0]   req_dst_stride,
    output logic [LEN_W-1:0]   req_src_stride,
    input  logic               resp_valid,
    input  logic               resp_eot,
    input  logic [31:0]        dbg_dst_addr,
    input  logic [31:0]        dbg_src_addr,
    input  logic [31:0]        dbg_status,
    input  logic [31:0]        dbg_id0,
    input  logic [31:0]        dbg_id1
);

    localparam logic [DADDR_W-1:0] ADDR_KEEP = {DADDR_W{1'b1}} << BEAT_W;
    localparam logic [LEN_W-1:0]   STR_KEEP  = {LEN_W{1'b1}} << BEAT_W;
    localparam logic [LEN_W-1:0]   ALIGN_SET = {LEN_W{1'b1}} >> (LEN_W - ALIGN_W);

    typedef struct packed {
        logic               enable;
        logic [2:0]         flags;
        logic [31:0]        scratch;
        logic [DADDR_W-1:0] dst;
        logic [DADDR_W-1:0] src;
        logic [LEN_W-1:0]   xlen;
        logic [LEN_W-1:0]   ylen;
        logic [LEN_W-1:0]   dstr;
        logic [LEN_W-1:0]   sstr;
        logic               submit;
        logic [31:0]        xid;
    } reg_st_t;

    reg_st_t     st_d, st_q;
    logic        accept;
    logic [31:0] wd;

    assign wd = wr_i.wdata;

    always_comb begin
        st_d   = st_q;
        accept = st_q.submit && req_ready;
        if (accept) begin
            st_d.submit = 1'b0;
            st_d.xid    = st_q.xid + 32'd1;
        end
        if (wr_i.wen) begin
            unique case (wr_i.widx)
                W_SCRATCH: st_d.scratch = wd;
                W_CTRL:    st_d.enable  = wd[0];
                W_SUBMIT:  if (wd[0]) st_d.submit = 1'b1;
                W_FLAGS:   st_d.flags   = wd[2:0];
                W_DST:     st_d.dst     = wd[DADDR_W-1:0] & ADDR_KEEP;
                W_SRC:     st_d.src     = wd[DADDR_W-1:0] & ADDR_KEEP;
                W_XLEN:    st_d.xlen    = wd[LEN_W-1:0] | ALIGN_SET;
                W_YLEN:    st_d.ylen    = wd[LEN_W-1:0];
                W_DSTRIDE: st_d.dstr    = wd[LEN_W-1:0] & STR_KEEP;
                W_SSTRIDE: st_d.sstr    = wd[LEN_W-1:0] & STR_KEEP;
                default:   ;
            endcase
        end
        set_o = {resp_valid && resp_eot, accept};
    end

    always_comb begin
        unique case (rd_idx_i)
            W_VERSION:  rd_data_o = VERSION_WORD;
            W_SCRATCH:  rd_data_o = st_q.scratch;
            W_IDENT:    rd_data_o = IDENT_WORD;
            W_IFACE:    rd_data_o = IFACE_WORD;
            W_IRQ_MASK: rd_data_o = 32'(mask_i);
            W_IRQ_PEND: rd_data_o = 32'(pend_i & mask_i);
            W_IRQ_RAW:  rd_data_o = 32'(pend_i);
            W_CTRL:     rd_data_o = 32'(st_q.enable);
            W_XFER_ID:  rd_data_o = st_q.xid;
            W_SUBMIT:   rd_data_o = 32'(st_q.submit);
            W_FLAGS:    rd_data_o = 32'(st_q.flags);
            W_DST:      rd_data_o = 32'(st_q.dst);
            W_SRC:      rd_data_o = 32'(st_q.src);
            W_XLEN:     rd_data_o = 32'(st_q.xlen);
            W_YLEN:     rd_data_o = 32'(st_q.ylen);
            W_DSTRIDE:  rd_data_o = 32'(st_q.dstr);
            W_SSTRIDE:  rd_data_o = 32'(st_q.sstr);
            W_DBG_DST:  rd_data_o = dbg_dst_addr;
            W_DBG_SRC:  rd_data_o = dbg_src_addr;
            W_DBG_STAT: rd_data_o = dbg_status;
            W_DBG_ID0:  rd_data_o = dbg_id0;
            W_DBG_ID1:  rd_data_o = dbg_id1;
            default:    rd_data_o = 32'h0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.flags <= 3'b011;
            st_q.xlen  <= ALIGN_SET;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable_o       = st_q.enable;
    assign flags_o        = st_q.flags;
    assign req_valid      = st_q.submit;
    assign req_dst_addr   = st_q.dst;
    assign req_src_addr   = st_q.src;
    assign req_xlen       = st_q.xlen;
    assign req_ylen       = st_q.ylen;
    assign req_dst_stride = st_q.dstr;
    assign req_src_stride = st_q.sstr;

endmodule

// File: rtl/dmac_csr_bank.sv
module dmac_csr_bank
    import dmac_csr_pkg::*;
#(
    parameter int DADDR_W = 32,
    parameter int LEN_W   = 24,
    parameter int BEAT_W  = 1,
    parameter int ALIGN_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  awvalid,
    output logic                  awready,
    input  logic [CSR_ADDR_W-1:0] awaddr,
    input  logic                  wvalid,
    output logic                  wready,
    input  logic [31:0]           wdata,
    output logic                  bvalid,
    input  logic                  bready,
    output logic [1:0]            bresp,
    input  logic                  arvalid,
    output logic                  arready,
    input  logic [CSR_ADDR_W-1:0] araddr,
    output logic                  rvalid,
    input  logic                  rready,
    output logic [31:0]           rdata,
    output logic [1:0]            rresp,
    output logic                  enable_o,
    output logic [2:0]            flags_o,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [DADDR_W-1:0]    req_dst_addr,
    output logic [DADDR_W-1:0]    req_src_addr,
    output logic [LEN_W-1:0]      req_xlen,
    output logic [LEN_W-1:0]      req_ylen,
    output logic [LEN_W-1:0]      req_dst_stride,
    output logic [LEN_W-1:0]      req_src_stride,
    input  logic                  resp_valid,
    output logic                  resp_ready,
    input  logic                  resp_eot,
    output logic                  irq,
    input  logic [31:0]           dbg_dst_addr,
    input  logic [31:0]           dbg_src_addr,
    input  logic [31:0]           dbg_status,
    input  logic [31:0]           dbg_id0,
    input  logic [31:0]           dbg_id1
);

    csr_wr_t            wr_w;
    logic [WORD_W-1:0]  rd_idx_w;
    logic [31:0]        rd_data_w;
    logic [IRQ_N-1:0]   pend_w;
    logic [IRQ_N-1:0]   mask_w;
    logic [IRQ_N-1:0]   set_w;

    assign resp_ready = 1'b1;

    dmac_csr_axil port_i (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
        .wvalid(wvalid), .wready(wready), .wdata(wdata),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .arvalid(arvalid), .arready(arready), .araddr(araddr),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
        .wr_o(wr_w), .rd_idx_o(rd_idx_w), .rd_data_i(rd_data_w)
    );

    dmac_csr_regs #(
        .DADDR_W(DADDR_W), .LEN_W(LEN_W), .BEAT_W(BEAT_W), .ALIGN_W(ALIGN_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_i(wr_w), .rd_idx_i(rd_idx_w), .rd_data_o(rd_data_w),
        .pend_i(pend_w), .mask_i(mask_w), .set_o(set_w),
        .enable_o(enable_o), .flags_o(flags_o),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_dst_addr(req_dst_addr), .req_src_addr(req_src_addr),
        .req_xlen(req_xlen), .req_ylen(req_ylen),
        .req_dst_stride(req_dst_stride), .req_src_stride(req_src_stride),
        .resp_valid(resp_valid), .resp_eot(resp_eot),
        .dbg_dst_addr(dbg_dst_addr), .dbg_src_addr(dbg_src_addr),
        .dbg_status(dbg_status), .dbg_id0(dbg_id0), .dbg_id1(dbg_id1)
    );

    dmac_csr_irq #(.N(IRQ_N)) irq_i (
        .clk(clk), .rst_n(rst_n),
        .wr_i(wr_w), .set_i(set_w),
        .pend_o(pend_w), .mask_o(mask_w), .irq_o(irq)
    );

endmodule

// File: rtl/dmac_csr_bank_chk.sv
module dmac_csr_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        resp_valid,
    input logic        resp_eot,
    input logic        irq,
    input logic        bvalid,
    input logic        bready,
    input logic [1:0]  bresp,
    input logic        rvalid,
    input logic        rready,
    input logic [1:0]  rresp,
    input logic [31:0] rdata,
    input logic [1:0]  pend_w
);

    a_r7_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid);

    a_r8_queued_posted: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> pend_w[0]);

    a_r9_done_posted: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_eot |=> pend_w[1]);

    a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(req_valid && req_ready) || $past(resp_valid && resp_eot) || $rose(bvalid)));

    a_r12_bresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> bresp == 2'b00);

    a_r12_rresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> rresp == 2'b00);

    a_r12_b_held: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);

    a_r12_r_held: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));

endmodule

bind dmac_csr_bank dmac_csr_bank_chk chk_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_eot(resp_eot), .irq(irq),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .rvalid(rvalid), .rready(rready), .rresp(rresp), .rdata(rdata),
    .pend_w(pend_w)
);

// File: tb/dmac_csr_bank_tb_top.sv
module dmac_csr_bank_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        awvalid = 0, wvalid = 0, arvalid = 0;
    logic        bready = 1, rready = 1;
    logic [10:0] awaddr = '0, araddr = '0;
    logic [31:0] wdata = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic        enable_o, req_valid, resp_ready, irq;
    logic [2:0]  flags_o;
    logic        req_ready = 0, resp_valid = 0, resp_eot = 0;
    logic [31:0] req_dst_addr, req_src_addr;
    logic [23:0] req_xlen, req_ylen, req_dst_stride, req_src_stride;

    localparam logic [31:0] DBG_D = 32'h1357_9BDF, DBG_S = 32'h2468_ACE0,
                            DBG_T = 32'h0000_05A5, DBG_0 = 32'hA1B2_C3D4,
                            DBG_1 = 32'h0F1E_2D3C;

    dmac_csr_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
        .wvalid(wvalid), .wready(wready), .wdata(wdata),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .arvalid(arvalid), .arready(arready), .araddr(araddr),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
        .enable_o(enable_o), .flags_o(flags_o),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_dst_addr(req_dst_addr), .req_src_addr(req_src_addr),
        .req_xlen(req_xlen), .req_ylen(req_ylen),
        .req_dst_stride(req_dst_stride), .req_src_stride(req_src_stride),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_eot(resp_eot),
        .irq(irq),
        .dbg_dst_addr(DBG_D), .dbg_src_addr(DBG_S), .dbg_status(DBG_T),
        .dbg_id0(DBG_0), .dbg_id1(DBG_1)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;
        logic [10:0] addr;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares each read beat against the oldest expected item
    always @(negedge clk) begin
        if (rst_n && rvalid && rready) begin
            if (sb_q.size() == 0) begin
                check("R12 unexpected read beat", rdata, 32'hx);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check($sformatf("%s @%h", it.tag, it.addr), rdata, it.exp);
                check("R12 rresp okay", {30'h0, rresp}, 32'h0);
            end
        end
    end

    task automatic send_aw(input logic [10:0] a);
        bit hs;
        @(negedge clk);
        awaddr = a; awvalid = 1;
        do begin hs = awready; @(posedge clk); #1; end while (!hs);
        awvalid = 0;
    endtask

    task automatic send_w(input logic [31:0] d);
        bit hs;
        @(negedge clk);
        wdata = d; wvalid = 1;
        do begin hs = wready; @(posedge clk); #1; end while (!hs);
        wvalid = 0;
    endtask

    task automatic wait_b();
        while (!bvalid) begin @(posedge clk); #1; end
        check("R12 bresp okay", {30'h0, bresp}, 32'h0);
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        fork
            send_aw(a);
            send_w(d);
        join
        wait_b();
    endtask

    task automatic rd_exp(input logic [10:0] a, input logic [31:0] e, input string tag);
        bit hs;
        sb_q.push_back('{exp: e, addr: a, tag: tag});
        @(negedge clk);
        araddr = a; arvalid = 1;
        do begin hs = arready; @(posedge clk); #1; end while (!hs);
        arvalid = 0;
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic check_reset_state(input string tag);
        rd_exp(11'h000, 32'h0004_0361, {tag, " R2 version"});
        rd_exp(11'h00C, 32'h444D_4143, {tag, " R2 ident"});
        rd_exp(11'h010, 32'h0000_2101, {tag, " R2 iface"});
        rd_exp(11'h080, 32'h3, {tag, " R2 mask"});
        rd_exp(11'h40C, 32'h3, {tag, " R2 flags"});
        rd_exp(11'h418, 32'h3, {tag, " R5 xlen reset"});
        rd_exp(11'h008, 32'h0, {tag, " R2 scratch"});
        rd_exp(11'h400, 32'h0, {tag, " R2 ctrl"});
        rd_exp(11'h404, 32'h0, {tag, " R2 xfer id"});
        rd_exp(11'h408, 32'h0, {tag, " R2 submit"});
        rd_exp(11'h088, 32'h0, {tag, " R2 raw pend"});
        rd_exp(11'h410, 32'h0, {tag, " R2 dst"});
        rd_exp(11'h41C, 32'h0, {tag, " R2 ylen"});
        rd_exp(11'h424, 32'h0, {tag, " R2 src stride"});
        check({tag, " R6 enable out"}, {31'h0, enable_o}, 32'h0);
        check({tag, " R6 flags out"}, {29'h0, flags_o}, 32'h3);
        check({tag, " R7 req_valid"}, {31'h0, req_valid}, 32'h0);
        check({tag, " R10 irq"}, {31'h0, irq}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        check_reset_state("reset");

        // R1 undecoded words
        rd_exp(11'h014, 32'h0, "R1 undecoded 0x014");
        rd_exp(11'h7FC, 32'h0, "R1 undecoded 0x7FC");
        wr(11'h014, 32'hFFFF_FFFF);
        rd_exp(11'h014, 32'h0, "R1 undecoded after write");
        // R2 read-only identity
        wr(11'h000, 32'h0);
        rd_exp(11'h000, 32'h0004_0361, "R2 version read-only");

        // R3 scratch, R12 split channels in both orders
        wr(11'h008, 32'h1234_5678);
        rd_exp(11'h008, 32'h1234_5678, "R3 scratch");
        send_w(32'hCAFE_F00D);
        rd_exp(11'h008, 32'h1234_5678, "R12 data alone does not write");
        send_aw(11'h008);
        wait_b();
        rd_exp(11'h008, 32'hCAFE_F00D, "R12 data before address");
        send_aw(11'h008);
        repeat (3) @(posedge clk);
        send_w(32'h0BAD_BEEF);
        wait_b();
        rd_exp(11'h008, 32'h0BAD_BEEF, "R12 address before data");

        // R4 address and stride alignment
        wr(11'h410, 32'hFFFF_FFFF);
        wr(11'h414, 32'h1234_5679);
        wr(11'h420, 32'hFFFF_FFFF);
        wr(11'h424, 32'h0000_0101);
        rd_exp(11'h410, 32'hFFFF_FFFE, "R4 dst addr");
        rd_exp(11'h414, 32'h1234_5678, "R4 src addr");
        rd_exp(11'h420, 32'h00FF_FFFE, "R4 dst stride");
        rd_exp(11'h424, 32'h0000_0100, "R4 src stride");
        check("R4 dst addr out", req_dst_addr, 32'hFFFF_FFFE);
        check("R4 src stride out", {8'h0, req_src_stride}, 32'h100);

        // R5 lengths
        wr(11'h418, 32'h0000_1230);
        wr(11'h41C, 32'hFFFF_FFFF);
        rd_exp(11'h418, 32'h0000_1233, "R5 xlen align");
        rd_exp(11'h41C, 32'h00FF_FFFF, "R5 ylen full");
        check("R5 xlen out", {8'h0, req_xlen}, 32'h1233);
        check("R5 ylen out", {8'h0, req_ylen}, 32'hFF_FFFF);

        // R6 control and flags
        wr(11'h400, 32'hFFFF_FFFF);
        wr(11'h40C, 32'h0000_0005);
        rd_exp(11'h400, 32'h1, "R6 ctrl readback");
        rd_exp(11'h40C, 32'h5, "R6 flags readback");
        check("R6 enable out", {31'h0, enable_o}, 32'h1);
        check("R6 flags out", {29'h0, flags_o}, 32'h5);

        // R11 debug words
        rd_exp(11'h434, DBG_D, "R11 dbg dst");
        rd_exp(11'h438, DBG_S, "R11 dbg src");
        rd_exp(11'h43C, DBG_T, "R11 dbg status");
        rd_exp(11'h440, DBG_0, "R11 dbg id0");
        rd_exp(11'h444, DBG_1, "R11 dbg id1");

        // R7 submit and hold
        wr(11'h408, 32'h1);
        repeat (3) @(posedge clk);
        #1;
        check("R7 req_valid held", {31'h0, req_valid}, 32'h1);
        rd_exp(11'h408, 32'h1, "R7 submit reads 1");
        // R8 acceptance
        @(negedge clk); req_ready = 1;
        @(posedge clk); #1; req_ready = 0;
        check("R7 req_valid cleared", {31'h0, req_valid}, 32'h0);
        check("R10 irq after accept", {31'h0, irq}, 32'h1);
        rd_exp(11'h408, 32'h0, "R7 submit reads 0");
        rd_exp(11'h404, 32'h1, "R8 id advanced");
        rd_exp(11'h088, 32'h1, "R8 queued pending");
        rd_exp(11'h084, 32'h1, "R10 masked pending");

        // R9 responses
        @(negedge clk); resp_valid = 1; resp_eot = 0;
        @(posedge clk); #1; resp_valid = 0;
        check("R9 resp_ready", {31'h0, resp_ready}, 32'h1);
        rd_exp(11'h088, 32'h1, "R9 no eot no effect");
        @(negedge clk); resp_valid = 1; resp_eot = 1;
        @(posedge clk); #1; resp_valid = 0; resp_eot = 0;
        rd_exp(11'h088, 32'h3, "R9 done pending");

        // R10 mask and clear
        wr(11'h080, 32'h0);
        check("R10 irq masked off", {31'h0, irq}, 32'h0);
        rd_exp(11'h084, 32'h0, "R10 masked view");
        rd_exp(11'h088, 32'h3, "R10 raw unaffected by mask");
        wr(11'h080, 32'h3);
        check("R10 irq unmasked", {31'h0, irq}, 32'h1);
        wr(11'h084, 32'h0);
        rd_exp(11'h088, 32'h3, "R10 write 0 no clear");
        wr(11'h084, 32'h1);
        rd_exp(11'h088, 32'h2, "R10 clear bit0");
        check("R10 irq still on", {31'h0, irq}, 32'h1);
        wr(11'h084, 32'h2);
        rd_exp(11'h088, 32'h0, "R10 clear bit1");
        check("R10 irq off", {31'h0, irq}, 32'h0);

        // R8 second transfer
        wr(11'h408, 32'h1);
        @(negedge clk); req_ready = 1;
        @(posedge clk); #1; req_ready = 0;
        rd_exp(11'h404, 32'h2, "R8 id second");

        // R13 load all-ones then reset
        wr(11'h008, 32'hFFFF_FFFF);
        wr(11'h080, 32'hFFFF_FFFF);
        wr(11'h400, 32'hFFFF_FFFF);
        wr(11'h40C, 32'hFFFF_FFFF);
        wr(11'h410, 32'hFFFF_FFFF);
        wr(11'h414, 32'hFFFF_FFFF);
        wr(11'h418, 32'hFFFF_FFFF);
        wr(11'h41C, 32'hFFFF_FFFF);
        wr(11'h420, 32'hFFFF_FFFF);
        wr(11'h424, 32'hFFFF_FFFF);
        wr(11'h408, 32'h1);
        rd_exp(11'h40C, 32'h7, "R13 flags loaded");
        do_reset();
        check_reset_state("R13 after reset");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule